// File: doc/BRIEF.md
# Immediate-Operand Arithmetic and Logic Unit with Decode

This block executes the immediate-format arithmetic and logic group of a 32-bit RISC instruction set. Each cycle it takes an instruction word and the value read from the register named by the instruction's source field. It decodes the opcode, widens the 16-bit immediate in the way that opcode calls for, and computes the result. One clock edge later it presents the destination register index, the result, a write enable and an undefined-instruction flag.

The register file, loads, stores, branches and overflow traps are handled elsewhere. The block only decides what to write and where to write it.

Instruction fields: opcode in bits 31:26, source index in bits 25:21, destination index in bits 20:16, immediate in bits 15:0.

Top module: `imm_alu_top`

## Requirements
- R1: While reset is asserted, `result_o`, `dst_idx_o`, `wr_en_o` and `undef_o` are all zero.
- R2: Outputs reflect the instruction and source value present at the previous rising clock edge, and `dst_idx_o` equals bits 20:16 of that instruction.
- R3: Opcodes 8 and 9 give the source plus the sign-extended immediate, wrapped to 32 bits. Neither raises `undef_o` on overflow.
- R4: Opcode 10 gives 1 if the source is less than the sign-extended immediate as signed 32-bit values, and 0 otherwise.
- R5: Opcode 11 sign-extends the immediate, compares both operands as unsigned 32-bit values, and gives 1 or 0.
- R6: Opcodes 12, 13 and 14 give the bitwise AND, OR and XOR of the source with the zero-extended immediate.
- R7: Opcode 15 gives the immediate in bits 31:16 and zero in bits 15:0, regardless of the source value.
- R8: When the source field (bits 25:21) is 0, the source operand is taken as zero, whatever value `src_val_i` carries.
- R9: Any opcode outside 8 to 15 gives `undef_o` = 1, `wr_en_o` = 0 and `result_o` = 0.
- R10: Any opcode from 8 to 15 gives `wr_en_o` = 1 and `undef_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 32 | Instruction word |
| src_val_i | input | 32 | Value read for the source register field |
| dst_idx_o | output | 5 | Destination register index |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Register write request |
| undef_o | output | 1 | Opcode is not in this group |

## Verification
The assertions assume that reset is applied before the first clock edge and that `instr_i` and `src_val_i` carry known values at every rising edge. Each assertion compares registered outputs with the inputs sampled one edge earlier. They take effect only after the first edge following reset release.

The stimulus respects these assumptions. Reset is held from time zero, and every input is driven on the falling edge, so values are stable at the rising edge. The sweep visits all 64 opcodes. For each opcode it pairs boundary source values with boundary immediates, and it repeats every pairing with the source field set to zero.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  // Operation class selected by the decoder
  typedef enum logic [2:0] {
    OPK_ADD  = 3'd0,
    OPK_SLT  = 3'd1,
    OPK_SLTU = 3'd2,
    OPK_AND  = 3'd3,
    OPK_OR   = 3'd4,
    OPK_XOR  = 3'd5,
    OPK_HIGH = 3'd6
  } op_kind_e;

  // How the 16-bit immediate is widened
  typedef enum logic [1:0] {
    WID_SIGN = 2'd0,
    WID_ZERO = 2'd1,
    WID_UP   = 2'd2
  } widen_e;

  typedef struct packed {
    logic     legal;
    op_kind_e kind;
    widen_e   widen;
  } dec_t;

  // Group occupies opcodes 8..15: upper three opcode bits equal 001
  localparam logic [2:0] GROUP_TAG = 3'b001;

endpackage

// File: rtl/imm_alu_dec.sv
module imm_alu_dec
  import imm_alu_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode_i,
  output dec_t             dec_o
);
  localparam int SEL_W = 3;

  logic [SEL_W-1:0] sel;
  logic             in_group;

  assign sel      = opcode_i[SEL_W-1:0];
  assign in_group = (opcode_i[OPC_W-1:SEL_W] == GROUP_TAG);

  always_comb begin
    dec_o = '{legal: 1'b0, kind: OPK_ADD, widen: WID_SIGN};
    if (in_group) begin
      dec_o.legal = 1'b1;
      case (sel)
        3'd0, 3'd1: begin dec_o.kind = OPK_ADD;  dec_o.widen = WID_SIGN; end
        3'd2:       begin dec_o.kind = OPK_SLT;  dec_o.widen = WID_SIGN; end
        3'd3:       begin dec_o.kind = OPK_SLTU; dec_o.widen = WID_SIGN; end
        3'd4:       begin dec_o.kind = OPK_AND;  dec_o.widen = WID_ZERO; end
        3'd5:       begin dec_o.kind = OPK_OR;   dec_o.widen = WID_ZERO; end
        3'd6:       begin dec_o.kind = OPK_XOR;  dec_o.widen = WID_ZERO; end
        default:    begin dec_o.kind = OPK_HIGH; dec_o.widen = WID_UP;   end
      endcase
    end
  end
endmodule

// File: rtl/imm_alu_widen.sv
module imm_alu_widen
  import imm_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  widen_e           mode_i,
  output logic [XLEN-1:0]  wide_o
);
  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] as_sign, as_zero, as_up;

  generate
    if (PAD_W > 0) begin : g_pad
      assign as_sign = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      assign as_zero = {{PAD_W{1'b0}}, imm_i};
      assign as_up   = {imm_i, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign as_sign = imm_i;
      assign as_zero = imm_i;
      assign as_up   = imm_i;
    end
  endgenerate

  always_comb begin
    case (mode_i)
      WID_ZERO: wide_o = as_zero;
      WID_UP:   wide_o = as_up;
      default:  wide_o = as_sign;
    endcase
  end
endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
  import imm_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_kind_e        kind_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  logic lt_s, lt_u;

  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    case (kind_i)
      OPK_ADD:  y_o = a_i + b_i;
      OPK_SLT:  y_o = {{(XLEN-1){1'b0}}, lt_s};
      OPK_SLTU: y_o = {{(XLEN-1){1'b0}}, lt_u};
      OPK_AND:  y_o = a_i & b_i;
      OPK_OR:   y_o = a_i | b_i;
      OPK_XOR:  y_o = a_i ^ b_i;
      OPK_HIGH: y_o = b_i;
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/imm_alu_top.sv
module imm_alu_top
  import imm_alu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OPC_W  = 6,
  parameter int RIDX_W = 5,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   src_val_i,
  output logic [RIDX_W-1:0] dst_idx_o,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic              undef_o
);
  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int SRC_LSB = OPC_LSB - RIDX_W;
  localparam int DST_LSB = SRC_LSB - RIDX_W;

  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] src_idx, dst_idx;
  logic [IMM_W-1:0]  imm;
  dec_t              dec;
  logic [XLEN-1:0]   src_eff, imm_wide, alu_y;

  assign opc     = instr_i[XLEN-1:OPC_LSB];
  assign src_idx = instr_i[OPC_LSB-1:SRC_LSB];
  assign dst_idx = instr_i[SRC_LSB-1:DST_LSB];
  assign imm     = instr_i[IMM_W-1:0];

  // Register zero always reads as zero
  assign src_eff = (src_idx == '0) ? '0 : src_val_i;

  imm_alu_dec #(.OPC_W(OPC_W)) dec_i (
    .opcode_i (opc),
    .dec_o    (dec)
  );

  imm_alu_widen #(.XLEN(XLEN), .IMM_W(IMM_W)) widen_i (
    .imm_i  (imm),
    .mode_i (dec.widen),
    .wide_o (imm_wide)
  );

  imm_alu_core #(.XLEN(XLEN)) core_i (
    .kind_i (dec.kind),
    .a_i    (src_eff),
    .b_i    (imm_wide),
    .y_o    (alu_y)
  );

  // Next-state
  logic [RIDX_W-1:0] dst_d;
  logic [XLEN-1:0]   res_d;
  logic              wr_d, undef_d;

  always_comb begin
    dst_d   = dst_idx;
    res_d   = '0;
    wr_d    = 1'b0;
    undef_d = 1'b0;
    if (dec.legal) begin
      res_d = alu_y;
      wr_d  = 1'b1;
    end else begin
      undef_d = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_idx_o <= '0;
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      undef_o   <= 1'b0;
    end else begin
      dst_idx_o <= dst_d;
      result_o  <= res_d;
      wr_en_o   <= wr_d;
      undef_o   <= undef_d;
    end
  end
endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   instr_i,
  input logic [XLEN-1:0]   src_val_i,
  input logic [RIDX_W-1:0] dst_idx_o,
  input logic [XLEN-1:0]   result_o,
  input logic              wr_en_o,
  input logic              undef_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  logic [5:0]  opc;
  logic [31:0] opnd, sx;
  assign opc  = instr_i[31:26];
  assign opnd = (instr_i[25:21] == 5'd0) ? 32'd0 : src_val_i;
  assign sx   = {{16{instr_i[15]}}, instr_i[15:0]};

  // R1
  always_comb begin
    if (!rst_n) begin
      r1_reset_chk: assert (result_o == '0 && dst_idx_o == '0 && !wr_en_o && !undef_o);
    end
  end

  // R2
  dst_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> dst_idx_o == $past(instr_i[20:16]));

  // R3
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc == 6'd8 || opc == 6'd9) |->
      result_o == $past(opnd + sx) && !undef_o);

  // R4
  slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc == 6'd10) |-> result_o[XLEN-1:1] == '0);

  // R5
  sltu_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc == 6'd11) |-> result_o == {31'd0, $past(opnd < sx)});

  // R7
  upper_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc == 6'd15) |-> result_o == {$past(instr_i[15:0]), 16'h0});

  // R8
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc == 6'd13 && instr_i[25:21] == 5'd0) |->
      result_o == {16'h0, $past(instr_i[15:0])});

  // R9
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc[5:3] != 3'b001) |-> undef_o && !wr_en_o && result_o == '0);

  // R10
  legal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(opc[5:3] == 3'b001) |-> wr_en_o && !undef_o);
endmodule

bind imm_alu_top imm_alu_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr_i   (instr_i),
  .src_val_i (src_val_i),
  .dst_idx_o (dst_idx_o),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .undef_o   (undef_o)
);

// File: tb/imm_alu_top_tb_top.sv
`timescale 1ns/1ps
module imm_alu_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] src_val;
  logic [4:0]  dst_idx;
  logic [31:0] result;
  logic        wr_en;
  logic        undef_f;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  imm_alu_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr),
    .src_val_i (src_val),
    .dst_idx_o (dst_idx),
    .result_o  (result),
    .wr_en_o   (wr_en),
    .undef_o   (undef_f)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [33:0] model(input logic [31:0] ins, input logic [31:0] sv);
    logic [31:0] a, se, ze, y;
    logic [15:0] im;
    logic        ok;
    a  = (ins[25:21] == 5'd0) ? 32'd0 : sv;
    im = ins[15:0];
    se = {{16{im[15]}}, im};
    ze = {16'd0, im};
    ok = 1'b1;
    case (ins[31:26])
      6'd8, 6'd9: y = a + se;
      6'd10:      y = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      6'd11:      y = (a < se) ? 32'd1 : 32'd0;
      6'd12:      y = a & ze;
      6'd13:      y = a | ze;
      6'd14:      y = a ^ ze;
      6'd15:      y = {im, 16'd0};
      default: begin y = 32'd0; ok = 1'b0; end
    endcase
    return {~ok, ok, y};
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    if (ins[31:29] != 3'b001) return "R9";
    if (ins[25:21] == 5'd0 && ins[31:26] != 6'd15) return "R8";
    case (ins[31:26])
      6'd8, 6'd9: return "R3";
      6'd10:      return "R4";
      6'd11:      return "R5";
      6'd15:      return "R7";
      default:    return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s instr=%h src=%h actual=%h expected=%h", tag, instr, src_val, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] sv);
    logic [33:0] e;
    @(negedge clk);
    instr   = ins;
    src_val = sv;
    e = model(ins, sv);
    @(posedge clk);
    #1;
    chk(tag_of(ins), result, e[31:0]);
    chk("R2", {27'd0, dst_idx}, {27'd0, ins[20:16]});
    chk(e[32] ? "R10" : "R9", {30'd0, wr_en, undef_f}, {30'd0, e[32], e[33]});
  endtask

  logic [31:0] srcs [6];
  logic [15:0] imms [6];

  initial begin
    srcs = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
    rst_n   = 1'b0;
    instr   = {6'd13, 5'd3, 5'd7, 16'hFFFF};
    src_val = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs stay zero while reset is held
    chk("R1", result, 32'd0);
    chk("R1", {27'd0, dst_idx}, 32'd0);
    chk("R1", {30'd0, wr_en, undef_f}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int op = 0; op < 64; op++)
      for (int s = 0; s < 6; s++)
        for (int i = 0; i < 6; i++)
          for (int z = 0; z < 2; z++) begin
            logic [4:0] rs, rd;
            rs = (z == 0) ? 5'd0 : 5'((op + s) % 31 + 1);
            rd = 5'((op * 7 + s * 3 + i) % 32);
            apply({op[5:0], rs, rd, imms[i]}, srcs[s]);
          end

    // R5: unsigned compare against sign-extended immediate 0xFFFF (= 0xFFFFFFFF)
    apply({6'd11, 5'd4, 5'd9, 16'hFFFF}, 32'hFFFF_FFFE);
    chk("R5", result, 32'd1);
    // R7: source value has no influence on the upper-immediate result
    apply({6'd15, 5'd4, 5'd9, 16'h1234}, 32'hFFFF_FFFF);
    chk("R7", result, 32'h1234_0000);
    // R3: wrap-around sum, no undefined flag
    apply({6'd8, 5'd4, 5'd9, 16'h0001}, 32'hFFFF_FFFF);
    chk("R3", {result[31:1], result[0] | undef_f}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule